// File: doc/BRIEF.md
# Cascadable Serial Output-Latch Controller

This block turns a three-wire serial control stream (active-low select, serial clock, serial data) into eight registered on/off channel enables. All five external control inputs are asynchronous to the block. Each passes through a two-flop synchronizer clocked by a fast system clock, and the serial clock and select edges are then found by comparing each synchronized level with its value one cycle earlier. While select is low, every rising serial-clock edge shifts one data bit into an eight-stage register. The rising edge of select copies that register onto the channel enables.

The last register stage is launched on a serial data output at each falling serial-clock edge. Units can be chained by wiring one unit's serial output to the next unit's data input and sharing select. Two active-low override inputs force every register and enable bit to all ones or all zeros, and the all-zeros override wins. The serial pins carry neither a valid nor a ready signal, so there is no back-pressure: the sender paces the bits, and the system clock must run at least eight times faster than the serial clock.

Top module: `chain_latch_ctrl`

## Requirements
- R1: After a synchronous reset (`rst` high on a clock edge), `chan_en` is all zeros and `sdo` is 0.
- R2: While `sel_n` is low, each rising edge of `sck` shifts the register one place toward its top stage, and `sdi` enters the bottom stage.
- R3: A low-to-high transition of `sel_n` copies the shift register onto `chan_en`, whether `sck` is high or low at that moment.
- R4: Bit order: the first bit shifted in a frame of eight lands on `chan_en[7]` (channel 8), and the last bit lands on `chan_en[0]` (channel 1).
- R5: While `sel_n` is low, each falling edge of `sck` sets `sdo` to the top register stage. It therefore repeats the `sdi` bit taken eight rising edges earlier. After a full eight-bit frame, `sdo` shows the frame's first bit.
- R6: When a select-low period holds more or fewer than eight bits, the register keeps the eight most recent bits shifted in. With fewer, the older contents move up by the number of bits received.
- R7: `chan_en` keeps its value while `sel_n` is low. While `sel_n` is high, `sck` and `sdi` activity changes neither `chan_en`, `sdo` nor the shift register.
- R8: While `set_all_n` is low and `clr_all_n` is high, every register bit, every `chan_en` bit and `sdo` are 1, whatever the serial inputs do.
- R9: While `clr_all_n` is low, every register bit, every `chan_en` bit and `sdo` are 0. This holds even when `set_all_n` is also low.
- R10: A stable input change reaches the outputs on the third system-clock rising edge after it: two synchronizer stages, then the register update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Active-low frame select; its rising edge loads the outputs |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data input |
| set_all_n | input | 1 | Active-low force of all register and enable bits to 1 |
| clr_all_n | input | 1 | Active-low force of all register and enable bits to 0; wins over set |
| sdo | output | 1 | Serial data output for chaining |
| chan_en | output | NCH | Channel enables; bit 0 is channel 1 |

## Verification
The bench builds the block with its defaults: `NCH` = 8 and `SYNC_STAGES` = 2. Eight channels make the full space of 256 frame values small enough to shift in, latch and compare one by one. During each frame, `sdo` is checked after every falling edge against an arithmetic shift model. Two synchronizer stages fix the update at an exact edge count, so the bench can sample one edge before and one edge after the select rise takes effect. Short and long frames, a select rise with the serial clock high, idle-select activity and the override combinations are each driven directly.

// File: rtl/chain_pkg.sv
package chain_pkg;
  // Index of each raw control input inside the synchronizer bank
  localparam int IN_CS    = 0;
  localparam int IN_SCK   = 1;
  localparam int IN_SDI   = 2;
  localparam int IN_SET   = 3;
  localparam int IN_CLR   = 4;
  localparam int IN_COUNT = 5;

  // Idle level of each input, loaded into the synchronizers on reset
  localparam logic [IN_COUNT-1:0] IN_IDLE = 5'b11001;

  // Override mode applied to the register and latch
  typedef enum logic [1:0] {
    OVR_NONE = 2'd0,
    OVR_SET  = 2'd1,
    OVR_CLR  = 2'd2
  } ovr_t;
endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
  parameter int N      = 5,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[k] <= RST_VAL;
      else     stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/shift_core.sv
module shift_core
  import chain_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  ovr_t         ovr,
  input  logic         shift_en,
  input  logic         launch_en,
  input  logic         din,
  output logic [W-1:0] q,
  output logic         sdo
);
  always_ff @(posedge clk) begin
    if (rst)                 q <= '0;
    else if (ovr == OVR_CLR) q <= '0;
    else if (ovr == OVR_SET) q <= '1;
    else if (shift_en)       q <= {q[W-2:0], din};
  end

  always_ff @(posedge clk) begin
    if (rst)                 sdo <= 1'b0;
    else if (ovr == OVR_CLR) sdo <= 1'b0;
    else if (ovr == OVR_SET) sdo <= 1'b1;
    else if (launch_en)      sdo <= q[W-1];
  end

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_en && ovr == OVR_NONE) |=> (q[0] == $past(din) && q[W-1:1] == $past(q[W-2:0])));

  // R5
  sdo_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (launch_en && ovr == OVR_NONE) |=> (sdo == $past(q[W-1])));

  // R7
  sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!launch_en && ovr == OVR_NONE) |=> $stable(sdo));

  // R9
  reg_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr == OVR_CLR) |=> (q == '0 && !sdo));
endmodule

// File: rtl/out_hold.sv
module out_hold
  import chain_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  ovr_t         ovr,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)                 q <= '0;
    else if (ovr == OVR_CLR) q <= '0;
    else if (ovr == OVR_SET) q <= '1;
    else if (load)           q <= d;
  end

  // R9
  clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr == OVR_CLR) |=> (q == '0));

  // R8
  set_all_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr == OVR_SET) |=> (q == '1));

  // R3
  load_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (load && ovr == OVR_NONE) |=> (q == $past(d)));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && ovr == OVR_NONE) |=> $stable(q));
endmodule

// File: rtl/chain_latch_ctrl.sv
module chain_latch_ctrl
  import chain_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sel_n,
  input  logic           sck,
  input  logic           sdi,
  input  logic           set_all_n,
  input  logic           clr_all_n,
  output logic           sdo,
  output logic [NCH-1:0] chan_en
);
  logic [IN_COUNT-1:0] raw_in, sync_in;
  logic                sck_prev, cs_prev;
  logic                sck_rise, sck_fall, cs_rise, selected;
  ovr_t                ovr;
  logic [NCH-1:0]      shreg;

  assign raw_in[IN_CS]  = sel_n;
  assign raw_in[IN_SCK] = sck;
  assign raw_in[IN_SDI] = sdi;
  assign raw_in[IN_SET] = set_all_n;
  assign raw_in[IN_CLR] = clr_all_n;

  sync_bank #(
    .N(IN_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(IN_IDLE)
  ) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_in)
  );

  // one-cycle history for edge detection on clock and select
  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev <= IN_IDLE[IN_SCK];
      cs_prev  <= IN_IDLE[IN_CS];
    end else begin
      sck_prev <= sync_in[IN_SCK];
      cs_prev  <= sync_in[IN_CS];
    end
  end

  assign selected = ~sync_in[IN_CS];
  assign sck_rise = sync_in[IN_SCK] & ~sck_prev;
  assign sck_fall = ~sync_in[IN_SCK] & sck_prev;
  assign cs_rise  = sync_in[IN_CS] & ~cs_prev;

  always_comb begin
    if (!sync_in[IN_CLR])      ovr = OVR_CLR;
    else if (!sync_in[IN_SET]) ovr = OVR_SET;
    else                       ovr = OVR_NONE;
  end

  shift_core #(.W(NCH)) u_shift (
    .clk(clk), .rst(rst), .ovr(ovr),
    .shift_en(sck_rise & selected),
    .launch_en(sck_fall & selected),
    .din(sync_in[IN_SDI]),
    .q(shreg), .sdo(sdo)
  );

  out_hold #(.W(NCH)) u_hold (
    .clk(clk), .rst(rst), .ovr(ovr),
    .load(cs_rise), .d(shreg), .q(chan_en)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (chan_en == '0 && sdo == 1'b0));
endmodule

// File: tb/sim_chain_latch_ctrl.sv
module sim_chain_latch_ctrl;
  localparam int NCH = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic sel_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic set_all_n = 1'b1, clr_all_n = 1'b1;
  logic sdo;
  logic [NCH-1:0] chan_en;

  int checks = 0, errors = 0;
  logic [NCH-1:0] model = '0, latched = '0;
  logic sdo_exp = 1'b0;

  always #10 clk = ~clk;

  chain_latch_ctrl #(.NCH(NCH), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sck(sck), .sdi(sdi),
    .set_all_n(set_all_n), .clr_all_n(clr_all_n),
    .sdo(sdo), .chan_en(chan_en)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one full serial clock period, rising then falling edge
  task automatic send_bit(input logic b);
    sdi = b;
    wait_n(4);
    sck = 1'b1;
    wait_n(4);
    model = {model[NCH-2:0], b};
    sck = 1'b0;
    wait_n(4);
    sdo_exp = model[NCH-1];
  endtask

  task automatic cs_pulse_load();
    sel_n = 1'b0;
    wait_n(4);
    sel_n = 1'b1;
    wait_n(4);
    latched = model;
  endtask

  task automatic frame8(input logic [7:0] v);
    sel_n = 1'b0;
    wait_n(4);
    for (int i = 7; i >= 0; i--) begin
      send_bit(v[i]);
      chk("R5 sdo after falling edge", {31'd0, sdo}, {31'd0, sdo_exp});
      chk("R7 enables held while selected", {24'd0, chan_en}, {24'd0, latched});
    end
    sel_n = 1'b1;
    wait_n(4);
    latched = model;
    chk("R2 R3 frame latched", {24'd0, chan_en}, {24'd0, v});
    chk("R5 sdo shows first bit", {31'd0, sdo}, {31'd0, v[7]});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_n(5);
    rst = 1'b0;
    wait_n(1);
    // R1
    chk("R1 reset enables", {24'd0, chan_en}, 32'd0);
    chk("R1 reset sdo", {31'd0, sdo}, 32'd0);

    // R4 bit order
    frame8(8'h80);
    chk("R4 first bit on channel 8", {31'd0, chan_en[7]}, 32'd1);
    frame8(8'h01);
    chk("R4 last bit on channel 1", {31'd0, chan_en[0]}, 32'd1);
    chk("R4 channel 8 clear", {31'd0, chan_en[7]}, 32'd0);

    // R6 short frame of three bits
    frame8(8'hC3);
    sel_n = 1'b0;
    wait_n(4);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    sel_n = 1'b1;
    wait_n(4);
    chk("R6 short frame", {24'd0, chan_en}, {24'd0, 8'h1D});
    latched = model;

    // R6 long frame of thirteen bits
    sel_n = 1'b0;
    wait_n(4);
    for (int i = 12; i >= 0; i--) begin
      send_bit(13'h1A6B >> i);
      chk("R5 sdo in long frame", {31'd0, sdo}, {31'd0, sdo_exp});
    end
    sel_n = 1'b1;
    wait_n(4);
    chk("R6 long frame keeps last eight", {24'd0, chan_en}, {24'd0, 8'h6B});
    latched = model;

    // R3 select rises while sck is high
    sel_n = 1'b0;
    wait_n(4);
    for (int i = 7; i >= 1; i--) send_bit(8'h5A >> i);
    sdi = 1'b0;
    wait_n(4);
    sck = 1'b1;
    wait_n(4);
    model = {model[NCH-2:0], 1'b0};
    sel_n = 1'b1;
    wait_n(4);
    chk("R3 load with sck high", {24'd0, chan_en}, {24'd0, 8'h5A});
    latched = model;
    sck = 1'b0;
    wait_n(4);

    // R7 activity while deselected
    for (int i = 0; i < 10; i++) begin
      sdi = i[0];
      wait_n(4);
      sck = ~sck;
    end
    sck = 1'b0;
    wait_n(4);
    chk("R7 enables unchanged while deselected", {24'd0, chan_en}, {24'd0, latched});
    chk("R7 sdo unchanged while deselected", {31'd0, sdo}, {31'd0, sdo_exp});
    cs_pulse_load();
    chk("R7 register unchanged while deselected", {24'd0, chan_en}, {24'd0, 8'h5A});

    // R10 latency of a select rise
    sel_n = 1'b0;
    wait_n(4);
    for (int i = 7; i >= 0; i--) send_bit(8'hA5 >> i);
    @(negedge clk);
    sel_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    chk("R10 no update after two edges", {24'd0, chan_en}, {24'd0, 8'h5A});
    @(posedge clk);
    #1;
    chk("R10 update on third edge", {24'd0, chan_en}, {24'd0, 8'hA5});
    latched = model;
    wait_n(4);

    // R8 set-all overrides serial traffic
    sel_n = 1'b0;
    wait_n(4);
    set_all_n = 1'b0;
    wait_n(4);
    chk("R8 enables forced high", {24'd0, chan_en}, 32'hFF);
    chk("R8 sdo forced high", {31'd0, sdo}, 32'd1);
    send_bit(1'b0); send_bit(1'b0);
    chk("R8 set beats shifting", {24'd0, chan_en}, 32'hFF);
    set_all_n = 1'b1;
    wait_n(4);
    model = '1;
    sdo_exp = 1'b1;
    sel_n = 1'b1;
    wait_n(4);
    chk("R8 register forced high", {24'd0, chan_en}, 32'hFF);
    latched = model;

    // R9 clear-all wins over set-all
    set_all_n = 1'b0;
    clr_all_n = 1'b0;
    wait_n(4);
    chk("R9 clear beats set enables", {24'd0, chan_en}, 32'd0);
    chk("R9 clear beats set sdo", {31'd0, sdo}, 32'd0);
    clr_all_n = 1'b1;
    wait_n(4);
    chk("R8 set resumes after clear", {24'd0, chan_en}, 32'hFF);
    set_all_n = 1'b1;
    clr_all_n = 1'b0;
    wait_n(4);
    clr_all_n = 1'b1;
    wait_n(4);
    model = '0;
    sdo_exp = 1'b0;
    chk("R9 sdo cleared", {31'd0, sdo}, 32'd0);
    cs_pulse_load();
    chk("R9 register cleared", {24'd0, chan_en}, 32'd0);

    // R2 R3 R4 R5 exhaustive sweep of frame values
    for (int v = 0; v < 256; v++) frame8(v[7:0]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule